// File: doc/BRIEF.md
# Signed Pulse-Width Crossbar Input Modulator

This block converts a vector of signed activations into per-line pulse-width enables for an analogue crossbar, together with the per-line source-line switch selects that decide which potential each pulse reaches. Each activation becomes a pulse whose length in clock ticks equals its magnitude, within a modulation period of 2^(DATA_W-1) ticks. Software or a neighbouring controller writes activations one line at a time into a shadow store. It picks a mode in a one-bit mode register and raises `start`. The block then copies the shadow store and the mode into working registers and plays out the operation.

In fast mode a single period carries every nonzero input. A positive input drives its positive source line high and its negative source line low. A negative input does the opposite. In precise mode the operation spans four periods. Each period serves one pairing of input sign and weight polarity, in a fixed order. A phase index output tells the downstream counters which accumulation sign belongs to the current period. A one-cycle `done` marks the end. The shadow store and mode register stay writable during an operation, so the next vector can be staged while the current one runs.

Top module: `pwm_input_modulator`

## Requirements
- R1: After reset, `busy`, `done`, `phase_idx` and every `pulse_en` and switch-select bit are 0. Whenever `busy` is 0, all pulse and select outputs are 0.
- R2: When `start` is accepted, the working vector is driven from the following cycle. In every period that serves a line, the line's `pulse_en` is high during ticks 0 to m-1 of that period and low after, where m is the magnitude of its two's-complement value.
- R3: The value -128 (bit pattern 0x80) gives a pulse of 127 ticks, the full period less one.
- R4: A line holding 0 never raises `pulse_en` or any select in either mode.
- R5: Fast mode (`mode_four`=0) lasts one period of 128 cycles. A positive line raises `sel_pp` and `sel_nn` while it pulses. A negative line raises `sel_pn` and `sel_np` while it pulses.
- R6: Precise mode (`mode_four`=1) lasts four periods of 128 cycles, with `phase_idx` 0,1,2,3 in turn. Phase 0 pulses positive lines on `sel_pp`. Phase 1 pulses positive lines on `sel_nn`. Phase 2 pulses negative lines on `sel_pn`. Phase 3 pulses negative lines on `sel_np`. In fast mode `phase_idx` stays 0.
- R7: `done` is high for exactly one cycle, in the first cycle after the last tick. `busy` falls in that same cycle.
- R8: `start` while `busy` is ignored. The running operation keeps its length and timing.
- R9: `ld_en` writes `ld_data` into line `ld_addr` of the shadow store at any time. The working vector is copied from the shadow store only when `start` is accepted, so a write during an operation affects only the next one.
- R10: `mode_wr` loads `mode_four` into the mode register at any time. The mode is captured when `start` is accepted, so a write during an operation affects only the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Write strobe for the shadow activation store |
| ld_addr | input | ADDR_W | Line written by `ld_en` |
| ld_data | input | DATA_W | Two's-complement activation to store |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_four | input | 1 | Mode value: 1 precise four-period, 0 fast single-period |
| start | input | 1 | Request to begin an operation; accepted only when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| phase_idx | output | 2 | Current sign/polarity phase (0 in fast mode) |
| pulse_en | output | N_LINES | Per-line pulse enable |
| sel_pp | output | N_LINES | Positive source line to positive potential |
| sel_pn | output | N_LINES | Positive source line to negative potential |
| sel_np | output | N_LINES | Negative source line to positive potential |
| sel_nn | output | N_LINES | Negative source line to negative potential |

## Verification
A wrong tick or phase counter shows within one period as a pulse that ends on the wrong cycle, or as a `phase_idx` step at the wrong time. The operation then ends early or late, and `done` appears off its 128- or 512-cycle mark. A working vector that changes mid-operation, or a mode that changes mid-operation, shows as pulse lengths that no longer match the vector loaded before `start`. The same holds for a restart taken while busy. The bench catches these on the first affected cycle because it compares every output bit on every cycle of every operation. A wrong sign decode shows in the first pulsing cycle as a select on the wrong pair of source lines.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;

  typedef enum logic [1:0] {
    PH_POS_IN_POS_W = 2'd0,
    PH_POS_IN_NEG_W = 2'd1,
    PH_NEG_IN_POS_W = 2'd2,
    PH_NEG_IN_NEG_W = 2'd3
  } phase_t;

  typedef struct packed {
    logic pp;
    logic pn;
    logic np;
    logic nn;
  } sw_sel_t;

  // Does a line of the given sign take part in the current period?
  function automatic logic sign_serves(input logic four, input phase_t ph,
                                       input logic is_pos, input logic is_neg);
    if (!four) return is_pos | is_neg;
    if (ph == PH_POS_IN_POS_W || ph == PH_POS_IN_NEG_W) return is_pos;
    return is_neg;
  endfunction

  // Switch selects for a line that is pulsing now.
  function automatic sw_sel_t switch_for(input logic four, input phase_t ph,
                                         input logic is_pos, input logic on);
    sw_sel_t s;
    s = '0;
    if (on) begin
      if (!four) begin
        s.pp = is_pos;
        s.nn = is_pos;
        s.pn = !is_pos;
        s.np = !is_pos;
      end else begin
        unique case (ph)
          PH_POS_IN_POS_W: s.pp = 1'b1;
          PH_POS_IN_NEG_W: s.nn = 1'b1;
          PH_NEG_IN_POS_W: s.pn = 1'b1;
          default:         s.np = 1'b1;
        endcase
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/pwm_vec_store.sv
module pwm_vec_store #(
  parameter int N_LINES = 256,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [ADDR_W-1:0]           ld_addr,
  input  logic [DATA_W-1:0]           ld_data,
  input  logic                        capture,
  output logic [N_LINES*DATA_W-1:0]   work_vec
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] work_q;
    logic              hit;

    assign hit = ld_en && (ld_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        work_q   <= '0;
      end else begin
        if (hit)     shadow_q <= ld_data;
        if (capture) work_q   <= shadow_q;
      end
    end

    assign work_vec[i*DATA_W +: DATA_W] = work_q;
  end

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
  import pwm_mod_pkg::*;
#(
  parameter int TICK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_four,
  output logic              accept,
  output logic              last_tick,
  output logic              busy,
  output logic              done,
  output logic              four_q,
  output phase_t            phase,
  output logic [TICK_W-1:0] tick
);

  localparam logic [TICK_W-1:0] TICK_END = '1;

  logic period_end;

  assign accept     = start && !busy;
  assign period_end = busy && (tick == TICK_END);
  assign last_tick  = period_end && (!four_q || phase == PH_NEG_IN_NEG_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      four_q <= 1'b0;
      phase  <= PH_POS_IN_POS_W;
      tick   <= '0;
    end else begin
      done <= last_tick;
      if (accept) begin
        busy   <= 1'b1;
        four_q <= mode_four;
        phase  <= PH_POS_IN_POS_W;
        tick   <= '0;
      end else if (last_tick) begin
        busy  <= 1'b0;
        phase <= PH_POS_IN_POS_W;
        tick  <= '0;
      end else if (busy) begin
        tick <= tick + TICK_W'(1);
        if (period_end) phase <= phase_t'(phase + 2'd1);
      end
    end
  end

endmodule

// File: rtl/pwm_line_drive.sv
module pwm_line_drive
  import pwm_mod_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICK_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] value,
  input  logic              active,
  input  logic              four,
  input  phase_t            phase,
  input  logic [TICK_W-1:0] tick,
  output logic              pulse,
  output sw_sel_t           sel
);

  // Pulse length in ticks: magnitude, with the most negative code clipped.
  function automatic logic [TICK_W-1:0] pulse_len(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] neg;
    neg = (~v) + DATA_W'(1);
    if (!v[DATA_W-1]) return v[TICK_W-1:0];
    if (neg[DATA_W-1]) return '1;
    return neg[TICK_W-1:0];
  endfunction

  logic              is_neg;
  logic              is_pos;
  logic [TICK_W-1:0] len;

  assign is_neg = value[DATA_W-1];
  assign is_pos = !is_neg && (value != '0);
  assign len    = pulse_len(value);
  assign pulse  = active && sign_serves(four, phase, is_pos, is_neg) && (tick < len);
  assign sel    = switch_for(four, phase, is_pos, pulse);

endmodule

// File: rtl/pwm_input_modulator.sv
module pwm_input_modulator
  import pwm_mod_pkg::*;
#(
  parameter int N_LINES = 256,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic               mode_wr,
  input  logic               mode_four,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [1:0]         phase_idx,
  output logic [N_LINES-1:0] pulse_en,
  output logic [N_LINES-1:0] sel_pp,
  output logic [N_LINES-1:0] sel_pn,
  output logic [N_LINES-1:0] sel_np,
  output logic [N_LINES-1:0] sel_nn
);

  localparam int TICK_W = DATA_W - 1;

  logic                      mode_q;
  logic                      seq_accept;
  logic                      seq_last;
  logic                      seq_four;
  phase_t                    seq_phase;
  logic [TICK_W-1:0]         seq_tick;
  logic [N_LINES*DATA_W-1:0] work_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_wr) mode_q <= mode_four;
  end

  pwm_vec_store #(
    .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .capture(seq_accept), .work_vec(work_vec)
  );

  pwm_seq #(.TICK_W(TICK_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_four(mode_q),
    .accept(seq_accept), .last_tick(seq_last), .busy(busy), .done(done),
    .four_q(seq_four), .phase(seq_phase), .tick(seq_tick)
  );

  assign phase_idx = seq_phase;

  for (genvar i = 0; i < N_LINES; i++) begin : g_drv
    sw_sel_t s;
    pwm_line_drive #(.DATA_W(DATA_W), .TICK_W(TICK_W)) drv_i (
      .value(work_vec[i*DATA_W +: DATA_W]), .active(busy), .four(seq_four),
      .phase(seq_phase), .tick(seq_tick), .pulse(pulse_en[i]), .sel(s)
    );
    assign sel_pp[i] = s.pp;
    assign sel_pn[i] = s.pn;
    assign sel_np[i] = s.np;
    assign sel_nn[i] = s.nn;
  end

endmodule

// File: rtl/pwm_mod_chk.sv
module pwm_mod_chk #(
  parameter int N_LINES = 256,
  parameter int DATA_W  = 8,
  parameter int TICK_W  = DATA_W - 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      busy,
  input logic                      done,
  input logic [1:0]                phase_idx,
  input logic [N_LINES-1:0]        pulse_en,
  input logic [N_LINES-1:0]        sel_pp,
  input logic [N_LINES-1:0]        sel_pn,
  input logic [N_LINES-1:0]        sel_np,
  input logic [N_LINES-1:0]        sel_nn,
  input logic                      last_tick,
  input logic                      four_q,
  input logic [TICK_W-1:0]         tick,
  input logic [N_LINES*DATA_W-1:0] work_vec
);

  logic [N_LINES-1:0] zero_mask;
  logic [N_LINES-1:0] any_sel;

  always_comb begin
    for (int i = 0; i < N_LINES; i++)
      zero_mask[i] = (work_vec[i*DATA_W +: DATA_W] == '0);
  end
  assign any_sel = sel_pp | sel_pn | sel_np | sel_nn;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pulse_en == '0 && any_sel == '0));

  p_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((pulse_en & zero_mask) == '0 && (any_sel & zero_mask) == '0));

  p_single_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !four_q) |-> (sel_pp == sel_nn && sel_pn == sel_np));

  p_single_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !four_q) |-> phase_idx == 2'd0);

  p_four_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && four_q) |-> $onehot0({|sel_pp, |sel_pn, |sel_np, |sel_nn}));

  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && phase_idx != $past(phase_idx))
      |-> (phase_idx == $past(phase_idx) + 2'd1 && tick == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_tick) |=> (busy && tick == $past(tick) + TICK_W'(1)));

  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(work_vec));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(four_q));

endmodule

bind pwm_input_modulator pwm_mod_chk #(
  .N_LINES(N_LINES), .DATA_W(DATA_W), .TICK_W(DATA_W - 1)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .phase_idx(phase_idx), .pulse_en(pulse_en), .sel_pp(sel_pp),
  .sel_pn(sel_pn), .sel_np(sel_np), .sel_nn(sel_nn),
  .last_tick(seq_last), .four_q(seq_four), .tick(seq_tick),
  .work_vec(work_vec)
);

// File: tb/pwm_input_modulator_tb.sv
module pwm_input_modulator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int DW  = 8;
  localparam int AW  = 3;
  localparam int PER = 128;
  localparam int WATCHDOG = 100000;
  localparam int N_TAB = 6;

  // {mode_four, line7 .. line0}
  localparam logic [64:0] VEC_TAB [N_TAB] = '{
    {1'b0, 64'h10C040FF00807F01},
    {1'b1, 64'h10C040FF00807F01},
    {1'b1, 64'h0000000000000000},
    {1'b0, 64'h818181817F7F7F7F},
    {1'b1, 64'h3CFF01007F80FB05},
    {1'b0, 64'hE020FE0201008080}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic mode_wr = 1'b0;
  logic mode_four = 1'b0;
  logic start = 1'b0;
  logic busy, done;
  logic [1:0] phase_idx;
  logic [N-1:0] pulse_en, sel_pp, sel_pn, sel_np, sel_nn;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic signed [DW-1:0] cur_val [N];
  bit cur_four;
  int cnt [N];
  bit end_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_input_modulator #(.N_LINES(N), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .mode_wr(mode_wr), .mode_four(mode_four),
    .start(start), .busy(busy), .done(done), .phase_idx(phase_idx),
    .pulse_en(pulse_en), .sel_pp(sel_pp), .sel_pn(sel_pn),
    .sel_np(sel_np), .sel_nn(sel_nn)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles exp below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int mag(input logic signed [DW-1:0] v);
    int m;
    m = (v < 0) ? -int'(v) : int'(v);
    return (m > PER - 1) ? PER - 1 : m;
  endfunction

  task automatic load_line(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic set_mode(input bit f);
    @(negedge clk);
    mode_wr = 1'b1; mode_four = f;
    @(negedge clk);
    mode_wr = 1'b0;
    cur_four = f;
  endtask

  // mid: 0 none, 1 start while busy, 2 load line 2 with 0x11, 3 flip mode
  task automatic run_op(input int mid, input string tag);
    int n;
    bit p_ok, s_ok, ph_ok, b_ok;
    string p_msg, s_msg, ph_msg, b_msg;
    string sreq;
    n = cur_four ? 4 * PER : PER;
    sreq = cur_four ? "R6" : "R5";
    p_ok = 1; s_ok = 1; ph_ok = 1; b_ok = 1;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < n; c++) begin
      int ph, t;
      logic [N-1:0] ep, epp, epn, enp, enn;
      ph = cur_four ? c / PER : 0;
      t  = c % PER;
      for (int i = 0; i < N; i++) begin
        bit pos, neg, serve, p;
        pos = cur_val[i] > 0;
        neg = cur_val[i] < 0;
        serve = cur_four ? ((ph < 2) ? pos : neg) : (pos || neg);
        p = serve && (t < mag(cur_val[i]));
        ep[i] = p;
        if (cur_four) begin
          epp[i] = p && ph == 0; enn[i] = p && ph == 1;
          epn[i] = p && ph == 2; enp[i] = p && ph == 3;
        end else begin
          epp[i] = p && pos; enn[i] = p && pos;
          epn[i] = p && neg; enp[i] = p && neg;
        end
        cnt[i] += int'(pulse_en[i]);
      end
      if (p_ok && pulse_en !== ep) begin
        p_ok = 0;
        p_msg = $sformatf("R2 %s cycle %0d pulse_en got %b exp %b", tag, c, pulse_en, ep);
      end
      if (s_ok && {sel_pp, sel_pn, sel_np, sel_nn} !== {epp, epn, enp, enn}) begin
        s_ok = 0;
        s_msg = $sformatf("%s %s cycle %0d selects pp/pn/np/nn got %b %b %b %b exp %b %b %b %b",
                          sreq, tag, c, sel_pp, sel_pn, sel_np, sel_nn, epp, epn, enp, enn);
      end
      if (ph_ok && phase_idx !== 2'(ph)) begin
        ph_ok = 0;
        ph_msg = $sformatf("R6 %s cycle %0d phase_idx got %0d exp %0d", tag, c, phase_idx, ph);
      end
      if (b_ok && (busy !== 1'b1 || done !== 1'b0)) begin
        b_ok = 0;
        b_msg = $sformatf("R7 %s cycle %0d busy/done got %b%b exp 10", tag, c, busy, done);
      end
      if (c == 40) begin
        if (mid == 1) start = 1'b1;
        if (mid == 2) begin ld_en = 1'b1; ld_addr = AW'(2); ld_data = 8'h11; end
        if (mid == 3) begin mode_wr = 1'b1; mode_four = !cur_four; end
      end
      if (c == 41) begin
        start = 1'b0; ld_en = 1'b0; mode_wr = 1'b0;
      end
      @(negedge clk);
    end
    if (b_ok && (busy !== 1'b0 || done !== 1'b1)) begin
      b_ok = 0;
      b_msg = $sformatf("R7 %s end busy/done got %b%b exp 01", tag, busy, done);
    end
    @(negedge clk);
    if (b_ok && done !== 1'b0) begin
      b_ok = 0;
      b_msg = $sformatf("R7 %s done held got %b exp 0", tag, done);
    end
    chk(p_ok, p_msg);
    chk(s_ok, s_msg);
    chk(ph_ok, ph_msg);
    chk(b_ok, b_msg);
    end_ok = b_ok;
  endtask

  task automatic load_all(input logic [63:0] v);
    for (int i = 0; i < N; i++) begin
      cur_val[i] = v[i*DW +: DW];
      load_line(i, v[i*DW +: DW]);
    end
  endtask

  initial begin
    cur_four = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && phase_idx === 2'd0 && pulse_en === '0 &&
        {sel_pp, sel_pn, sel_np, sel_nn} === '0,
        $sformatf("R1 reset outputs got busy=%b done=%b ph=%0d pulse=%b exp all 0",
                  busy, done, phase_idx, pulse_en));

    // Table walk: R2, R5/R6, R7
    for (int k = 0; k < N_TAB; k++) begin
      load_all(VEC_TAB[k][63:0]);
      set_mode(VEC_TAB[k][64]);
      run_op(0, $sformatf("table[%0d]", k));
    end

    // R3 and R4: clipping and zero lines, precise mode
    load_all(64'h40_00_81_7F_FF_01_00_80);
    set_mode(1);
    run_op(0, "clip");
    chk(cnt[0] == 254, $sformatf("R3 -128 line pulse ticks got %0d exp 254", cnt[0]));
    chk(cnt[4] == 254, $sformatf("R3 +127 line pulse ticks got %0d exp 254", cnt[4]));
    chk(cnt[1] == 0 && cnt[6] == 0,
        $sformatf("R4 zero lines pulse ticks got %0d,%0d exp 0,0", cnt[1], cnt[6]));
    chk(cnt[2] == 2, $sformatf("R2 +1 line pulse ticks got %0d exp 2", cnt[2]));

    // R8: start while busy is ignored
    set_mode(0);
    run_op(1, "restart");
    chk(end_ok, "R8 restart while busy changed operation length got bad exp 128 cycles");
    @(negedge clk);
    chk(busy === 1'b0, $sformatf("R8 busy after ignored start got %b exp 0", busy));

    // R9: load during operation only affects the next one
    load_all(64'h00_00_00_00_00_22_00_00);
    run_op(2, "load-during");
    chk(cnt[2] == 34, $sformatf("R9 running op used line2 ticks got %0d exp 34", cnt[2]));
    cur_val[2] = 8'h11;
    run_op(0, "load-next");
    chk(cnt[2] == 17, $sformatf("R9 next op line2 ticks got %0d exp 17", cnt[2]));

    // R10: mode write during operation only affects the next one
    run_op(3, "mode-during");
    chk(end_ok, "R10 mode write changed running op length got bad exp 128 cycles");
    cur_four = 1;
    run_op(0, "mode-next");
    chk(end_ok, "R10 next op did not run four periods got bad exp 512 cycles");

    summary();
    $finish;
  end

endmodule